// File: doc/BRIEF.md
# Infrared Frame Receiver with Station Address Filter

This block turns a serial infrared bit stream, already demodulated and already timed by an upstream bit strobe, into a stream of received bytes. Frames are bounded by the flag octet `0111_1110`. Inside a frame the transmitter inserts a 0 after every run of five 1 bits. The receiver removes those stuffed bits, builds bytes least significant bit first, and runs a 16-bit CRC over every bit between the flags. It also decides from the first byte whether the frame is meant for this station. The address byte and every following byte, control bytes included, go out as plain data. The two CRC bytes are consumed and never delivered.

Because the receiver only learns that a frame has ended when the closing flag arrives, it holds the three most recent bytes back. A byte is released when a newer byte pushes it out. At the closing flag the oldest held byte goes out tagged as end of frame, with the CRC verdict beside it. Broken frames produce a single status record. A broken frame is one whose length is not a whole number of octets, or one cut short by seven or more 1 bits. The status record has byte 0x00, the end-of-frame tag and the abort bit. The consumer writes the records into its own buffer.

Control FSM states:
- `ST_HUNT`: the receiver waits for a flag. After reset it starts here, and it comes back here after an abort.
- `ST_OPEN`: a flag has been seen and no frame bits have arrived yet.
- `ST_ADDR`: the address byte is being collected.
- `ST_BODY`: the frame has been accepted and bytes are being collected.
- `ST_SKIP`: the frame has been filtered out and the receiver waits for the next flag.

Transitions:
- HUNT→OPEN on a flag.
- OPEN→OPEN on a flag (idle).
- OPEN→ADDR on the first data bit.
- ADDR→BODY on an address byte that is accepted.
- ADDR→SKIP on an address byte that is rejected.
- ADDR/BODY/SKIP→OPEN on a flag.
- OPEN/ADDR/BODY/SKIP→HUNT on an abort run.

Top module: `ir_frame_rx`

## Requirements
- R1: After reset `out_vld`, `out_eof`, `out_crc_err`, `out_abort` are 0 and `out_byte` is 0x00.
- R2: The flag `0111_1110` starts and ends frames. Back-to-back flags with no bits between them are idle and produce no output.
- R3: A 0 that follows five consecutive 1 bits inside a frame is removed and is not counted as frame data.
- R4: Bytes are assembled from the first received bit as bit 0. The address byte is delivered first, then every later byte in arrival order, except the final two bytes (the CRC), which are never delivered.
- R5: The last delivered byte of a good-length frame carries `out_eof`=1. Every other data byte carries `out_eof`=0.
- R6: The CRC register uses polynomial 0x1021 and is preset to 0xFFFF. It shifts toward the MSB, and its feedback is bit 15 XOR the input bit. It is updated with every frame bit in arrival order, CRC bits included. A final value other than 0x1D0F sets `out_crc_err` on the end-of-frame byte. The transmitter appends its inverted CRC, MSB first.
- R7: With `match_en`=1, a frame whose address byte equals neither `station_addr` nor 0xFF produces no output at all.
- R8: With `match_en`=0, every frame is delivered whatever its address. With `match_en`=1, address 0xFF and the programmed address are delivered.
- R9: A frame whose bit count between the flags is not a multiple of 8 yields exactly one record: byte 0x00, `out_eof`=1, `out_abort`=1, `out_crc_err`=0. Its held bytes are discarded.
- R10: Seven consecutive 1 bits inside a frame yield the same single abort record. The receiver then ignores everything until the next flag, and the frames after that flag are received normally.
- R11: An octet-aligned frame shorter than three bytes (address plus 16-bit CRC) produces no output.
- R12: `bit_in` has no effect while `bit_vld` is 0.
- R13: Each output record is a one-cycle `out_vld` pulse that appears one clock after the `bit_vld` cycle that caused it. `out_eof` is set only with `out_vld`, `out_abort` only with `out_eof`, and `out_crc_err` only on a non-abort end-of-frame record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Serial line bit |
| bit_vld | input | 1 | Strobe: `bit_in` holds a new bit this cycle |
| station_addr | input | 8 | Programmed address of this station |
| match_en | input | 1 | 1 = drop frames addressed to other stations |
| out_vld | output | 1 | A byte record is presented this cycle |
| out_byte | output | 8 | Received byte, or 0x00 on an abort record |
| out_eof | output | 1 | Record is the last one of its frame |
| out_crc_err | output | 1 | Frame CRC residue was wrong (end-of-frame only) |
| out_abort | output | 1 | Frame ended in an abort or on a non-octet boundary |

## Verification
The assertions check the rules that hold on every cycle, on both good and broken frames. These rules cover how the status bits relate to the valid pulse, that the abort record carries a zero byte, and that no record appears without a preceding bit strobe. The bench's scenarios are needed for the rest. They show the byte order, that the CRC bytes are stripped, the CRC verdict, stuffing removal on payloads full of 1s, the full 256-value address sweep under the filter, the short and non-octet frames, and recovery after an abort run. The bench drives random values on `bit_in` between strobes. So every scenario also shows that unstrobed bits are ignored.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
    localparam int BYTE_W     = 8;
    localparam int CRC_W      = 16;
    localparam int CRC_BYTES  = CRC_W / BYTE_W;
    localparam int HOLD_N     = CRC_BYTES + 1;
    localparam int RUN_STUFF  = 5;
    localparam int RUN_FLAG   = RUN_STUFF + 1;
    localparam int DLY_LEN    = RUN_FLAG + 1;
    localparam logic [CRC_W-1:0] CRC_POLY    = 16'h1021;
    localparam logic [CRC_W-1:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_GOOD    = 16'h1D0F;
    localparam logic [BYTE_W-1:0] ADDR_BCAST = 8'hFF;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_OPEN,
        ST_ADDR,
        ST_BODY,
        ST_SKIP
    } rx_state_e;
endpackage

// File: rtl/ir_rx_bitproc.sv
module ir_rx_bitproc
    import ir_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    output logic d_vld,
    output logic d_bit,
    output logic flag_p,
    output logic abort_p
);
    localparam int RUN_W  = $clog2(RUN_FLAG + 2);
    localparam int FILL_W = $clog2(DLY_LEN + 1);

    logic [RUN_W-1:0]   ones;
    logic [DLY_LEN-1:0] dly;
    logic [FILL_W-1:0]  fill;
    logic               is_stuff;
    logic               is_data;
    logic               dly_full;

    // Run-length decode of the raw line bits.
    always_comb begin
        flag_p   = bit_vld && !bit_in && (ones == RUN_W'(RUN_FLAG));
        is_stuff = bit_vld && !bit_in && (ones == RUN_W'(RUN_STUFF));
        abort_p  = bit_vld &&  bit_in && (ones == RUN_W'(RUN_FLAG));
        is_data  = bit_vld && !flag_p && !is_stuff &&
                   !(bit_in && (ones >= RUN_W'(RUN_FLAG)));
        dly_full = (fill == FILL_W'(DLY_LEN));
        // Bits leave only once they are known not to belong to a flag.
        d_vld    = is_data && dly_full;
        d_bit    = dly[DLY_LEN-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones <= '0;
            dly  <= '0;
            fill <= '0;
        end else begin
            if (bit_vld) begin
                if (!bit_in)
                    ones <= '0;
                else if (ones <= RUN_W'(RUN_FLAG))
                    ones <= ones + RUN_W'(1);
            end
            if (flag_p || abort_p)
                fill <= '0;
            else if (is_data && !dly_full)
                fill <= fill + FILL_W'(1);
            if (is_data)
                dly <= {dly[DLY_LEN-2:0], bit_in};
        end
    end
endmodule

// File: rtl/ir_rx_crc.sv
module ir_rx_crc
    import ir_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic fb;

    always_comb fb = crc[CRC_W-1] ^ din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc <= CRC_PRESET;
        else if (init)
            crc <= CRC_PRESET;
        else if (en)
            crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
endmodule

// File: rtl/ir_frame_rx.sv
module ir_frame_rx
    import ir_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic [BYTE_W-1:0] station_addr,
    input  logic              match_en,
    output logic              out_vld,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_eof,
    output logic              out_crc_err,
    output logic              out_abort
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam int NH_W  = $clog2(HOLD_N + 1);

    rx_state_e         state, state_nx;
    logic              d_vld, d_bit, flag_p, abort_p;
    logic [CRC_W-1:0]  crc;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] hold [HOLD_N];
    logic [NH_W-1:0]   nh;
    logic              byte_done;
    logic [BYTE_W-1:0] new_byte;
    logic              addr_ok;
    logic              hold_full;
    logic              in_frame;

    ir_rx_bitproc u_bitproc (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .d_vld   (d_vld),
        .d_bit   (d_bit),
        .flag_p  (flag_p),
        .abort_p (abort_p)
    );

    ir_rx_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (flag_p || abort_p),
        .en    (d_vld),
        .din   (d_bit),
        .crc   (crc)
    );

    always_comb begin
        byte_done = d_vld && (cnt == CNT_W'(BYTE_W - 1));
        new_byte  = {d_bit, sh[BYTE_W-1:1]};
        addr_ok   = !match_en || (new_byte == station_addr) ||
                    (new_byte == ADDR_BCAST);
        hold_full = (nh == NH_W'(HOLD_N));
        in_frame  = (state == ST_ADDR) || (state == ST_BODY);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_HUNT;
        else
            state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT: if (flag_p) state_nx = ST_OPEN;
            ST_OPEN: begin
                if (abort_p)     state_nx = ST_HUNT;
                else if (d_vld)  state_nx = ST_ADDR;
            end
            ST_ADDR: begin
                if (abort_p)        state_nx = ST_HUNT;
                else if (flag_p)    state_nx = ST_OPEN;
                else if (byte_done) state_nx = addr_ok ? ST_BODY : ST_SKIP;
            end
            ST_BODY, ST_SKIP: begin
                if (abort_p)     state_nx = ST_HUNT;
                else if (flag_p) state_nx = ST_OPEN;
            end
            default: state_nx = ST_HUNT;
        endcase
    end

    // Byte assembly, holding queue and output records
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh          <= '0;
            cnt         <= '0;
            nh          <= '0;
            out_vld     <= 1'b0;
            out_byte    <= '0;
            out_eof     <= 1'b0;
            out_crc_err <= 1'b0;
            out_abort   <= 1'b0;
            for (int i = 0; i < HOLD_N; i++) hold[i] <= '0;
        end else begin
            out_vld     <= 1'b0;
            out_byte    <= '0;
            out_eof     <= 1'b0;
            out_crc_err <= 1'b0;
            out_abort   <= 1'b0;

            if (flag_p || abort_p)
                cnt <= '0;
            else if (d_vld) begin
                sh  <= new_byte;
                cnt <= cnt + CNT_W'(1);
            end

            if (state == ST_ADDR && byte_done && addr_ok) begin
                hold[0] <= new_byte;
                nh      <= NH_W'(1);
            end

            if (state == ST_BODY && byte_done) begin
                if (hold_full) begin
                    out_vld  <= 1'b1;
                    out_byte <= hold[0];
                    for (int i = 0; i < HOLD_N - 1; i++) hold[i] <= hold[i+1];
                    hold[HOLD_N-1] <= new_byte;
                end else begin
                    for (int i = 0; i < HOLD_N; i++)
                        if (i == int'(nh)) hold[i] <= new_byte;
                    nh <= nh + NH_W'(1);
                end
            end

            if (in_frame && (abort_p || (flag_p && cnt != '0))) begin
                out_vld   <= 1'b1;
                out_eof   <= 1'b1;
                out_abort <= 1'b1;
            end else if (state == ST_BODY && flag_p && hold_full) begin
                out_vld     <= 1'b1;
                out_byte    <= hold[0];
                out_eof     <= 1'b1;
                out_crc_err <= (crc != CRC_GOOD);
            end

            if (flag_p || abort_p)
                nh <= '0;
        end
    end
endmodule

// File: rtl/ir_frame_rx_chk.sv
module ir_frame_rx_chk
    import ir_rx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bit_vld,
    input logic              out_vld,
    input logic [BYTE_W-1:0] out_byte,
    input logic              out_eof,
    input logic              out_crc_err,
    input logic              out_abort
);
    // R13
    eof_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_vld);

    // R9
    abort_is_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_abort |-> (out_eof && out_byte == '0));

    // R6
    crc_err_on_good_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_crc_err |-> (out_eof && !out_abort));

    // R12
    record_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld) |-> $past(bit_vld));

    // R13
    single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> (!out_vld || $past(bit_vld)));
endmodule

bind ir_frame_rx ir_frame_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_vld     (bit_vld),
    .out_vld     (out_vld),
    .out_byte    (out_byte),
    .out_eof     (out_eof),
    .out_crc_err (out_crc_err),
    .out_abort   (out_abort)
);

// File: tb/ir_frame_rx_tb.sv
module ir_frame_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_vld = 1'b0;
    logic [7:0] station_addr = 8'h00;
    logic       match_en = 1'b0;
    logic       out_vld;
    logic [7:0] out_byte;
    logic       out_eof, out_crc_err, out_abort;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int tx_ones = 0;
    logic [10:0] exp_q[$];
    logic [10:0] got_q[$];
    logic [7:0]  fb[$];

    always #5ns clk = ~clk;

    ir_frame_rx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .station_addr(station_addr), .match_en(match_en),
        .out_vld(out_vld), .out_byte(out_byte), .out_eof(out_eof),
        .out_crc_err(out_crc_err), .out_abort(out_abort)
    );

    // record layout: {abort, crc_err, eof, byte}
    always @(negedge clk)
        if (rst_n && out_vld) got_q.push_back({out_abort, out_crc_err, out_eof, out_byte});

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog R13 actual=%0d expected<190000 cycles", cyc);
            summary();
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put_bit(logic b);
        @(negedge clk); bit_in = b; bit_vld = 1'b1;
        @(negedge clk); bit_vld = 1'b0; bit_in = 1'($urandom);  // R12
    endtask

    task automatic send_raw(logic b);
        put_bit(b); tx_ones = 0;
    endtask

    task automatic send_stuffed(logic b);
        put_bit(b);
        tx_ones = b ? tx_ones + 1 : 0;
        if (tx_ones == 5) begin put_bit(1'b0); tx_ones = 0; end  // R3
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        for (int i = 0; i < 6; i++) send_raw(1'b1);
        send_raw(1'b0);
    endtask

    function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
        logic f = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
    endfunction

    // Sends fb[] as address/body with opening and closing flags.
    task automatic send_frame(logic [15:0] corrupt);
        logic [15:0] c = 16'hFFFF;
        logic [15:0] fcs;
        send_flag();
        foreach (fb[k])
            for (int i = 0; i < 8; i++) begin
                send_stuffed(fb[k][i]);
                c = crc_step(c, fb[k][i]);
            end
        fcs = ~c ^ corrupt;
        for (int i = 15; i >= 0; i--) send_stuffed(fcs[i]);
        send_flag();
    endtask

    task automatic expect_frame(logic err);
        foreach (fb[k])
            exp_q.push_back({1'b0, (k == fb.size() - 1) ? err : 1'b0,
                             (k == fb.size() - 1), fb[k]});
    endtask

    task automatic compare(string req);
        repeat (6) @(negedge clk);
        chk(got_q.size() == exp_q.size(), req, "record count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] == exp_q[i], req, "record", got_q[i], exp_q[i]);
        got_q.delete(); exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk({out_vld, out_eof, out_crc_err, out_abort, out_byte} == 12'h0,
            "R1", "reset outputs",
            {out_vld, out_eof, out_crc_err, out_abort, out_byte}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: idle flags only
        for (int i = 0; i < 4; i++) send_flag();
        compare("R2");

        // R4 R5 R6 R3: payload length sweep, good then corrupted CRC
        for (int bad = 0; bad < 2; bad++)
            for (int len = 0; len < 7; len++) begin
                fb.delete();
                fb.push_back(8'(8'hA0 + len));
                for (int i = 0; i < len; i++)
                    fb.push_back((i % 3 == 0) ? 8'hFF : (i % 3 == 1) ? 8'h7E : 8'(i * 29 + len));
                send_frame(bad ? 16'h0100 : 16'h0000);
                expect_frame(bad != 0);
                compare(bad ? "R6" : "R4 R5 R3");
            end

        // R7 R8: full address sweep with the filter on
        match_en = 1'b1; station_addr = 8'h5A;
        for (int a = 0; a < 256; a++) begin
            fb.delete(); fb.push_back(8'(a)); fb.push_back(8'(a) ^ 8'h33);
            send_frame(16'h0000);
            if (a == 8'h5A || a == 8'hFF) expect_frame(1'b0);
            compare((a == 8'h5A || a == 8'hFF) ? "R8" : "R7");
        end

        // R8: filter off delivers any address
        match_en = 1'b0;
        for (int a = 0; a < 256; a += 51) begin
            fb.delete(); fb.push_back(8'(a)); fb.push_back(8'hC3);
            send_frame(16'h0000);
            expect_frame(1'b0);
            compare("R8");
        end

        // R11: two-byte frame is dropped
        send_flag();
        for (int i = 0; i < 16; i++) send_stuffed(i[0]);
        send_flag();
        compare("R11");

        // R9: non-octet length, in body and during the address
        send_flag();
        for (int i = 0; i < 8; i++) send_stuffed(8'h12 >> i);
        for (int i = 0; i < 8; i++) send_stuffed(8'h34 >> i);
        send_stuffed(1'b1); send_stuffed(1'b0); send_stuffed(1'b1);
        send_flag();
        exp_q.push_back({1'b1, 1'b0, 1'b1, 8'h00});
        compare("R9");
        send_flag();
        for (int i = 0; i < 5; i++) send_stuffed(i[0]);
        send_flag();
        exp_q.push_back({1'b1, 1'b0, 1'b1, 8'h00});
        compare("R9");

        // R10: seven ones abort, then a clean frame
        send_flag();
        for (int i = 0; i < 8; i++) send_stuffed(8'h21 >> i);
        for (int i = 0; i < 8; i++) send_stuffed(8'h43 >> i);
        for (int i = 0; i < 8; i++) send_stuffed(8'h65 >> i);
        for (int i = 0; i < 7; i++) send_raw(1'b1);
        fb.delete(); fb.push_back(8'h77); fb.push_back(8'h01);
        send_frame(16'h0000);
        exp_q.push_back({1'b1, 1'b0, 1'b1, 8'h00});
        expect_frame(1'b0);
        compare("R10");

        summary();
    end
endmodule